// File: doc/BRIEF.md
# Partitioned SIMD Integer Execution Unit

This block is a pipelined integer execution unit that works on a 128-bit datapath. Each operation brings two 128-bit sources, a third 128-bit source that only the multiply-add uses, an opcode and a lane-size code. Bitwise logic treats the sources as one 128-bit word. Add, subtract and the two compares split the word into sixteen 8-bit, eight 16-bit or four 32-bit lanes, chosen separately for each operation. The multiply-add treats the word as four 32-bit lanes. In each lane it multiplies the signed low halves of the two sources and adds a 32-bit addend taken from the third source.

The unit can take a new operation in every cycle. A valid flag and a 7-bit destination tag travel through the three pipeline registers with the data. An operation presented in cycle t therefore shows its result, tag and valid flag in cycle t+3. The surrounding issue logic does not need to stall or arbitrate for the result port, because every opcode has the same latency.

Top module: `simd_int_unit`

## Requirements
- R1: An operation with `in_valid` high is accepted in every cycle, including back-to-back cycles, and each accepted operation produces exactly one result in issue order.
- R2: The result of an operation presented in cycle t appears on `out_data`, with its `in_tag` value on `out_tag` and `out_valid` high, in cycle t+3. `out_valid` is low in every cycle that has no result.
- R3: Synchronous active-low reset clears `out_valid`, `out_tag` and `out_data` to zero. No operation in flight when reset is applied ever produces a result.
- R4: Opcodes 0 (AND), 1 (OR), 2 (XOR) and 3 (NOR) act on all 128 bits, and the lane-size code has no effect on them.
- R5: Opcode 4 (ADD) adds each lane modulo 2^width, and no carry passes into the next lane. The lane-size code is 0 for 8-bit lanes, 1 for 16-bit lanes, and 2 or 3 for 32-bit lanes. Lane i occupies bits [i*w+w-1 : i*w].
- R6: Opcode 5 (SUB) computes a minus b in each lane, modulo 2^width, and no borrow passes between lanes.
- R7: Opcode 6 (CMPEQ) writes all ones into each lane where the a and b lanes are equal, and all zeros into every other lane.
- R8: Opcode 7 (CMPGT) writes all ones into each lane where the a lane is greater than the b lane as signed two's complement values, and all zeros into every other lane.
- R9: Opcode 8 (MADD) makes lane i (bits 32i+31..32i, i = 0..3) equal to the signed product of a[32i+15:32i] and b[32i+15:32i], plus c[32i+31:32i], wrapped modulo 2^32. The lane-size code has no effect on it.
- R10: Opcodes 9 to 15 produce an all-zero result, and their valid flag and tag are carried as usual.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | An operation is presented this cycle |
| in_op | input | 4 | Opcode |
| in_lsz | input | 2 | Lane-size code (0: 8-bit, 1: 16-bit, 2/3: 32-bit) |
| in_tag | input | 7 | Destination tag carried to the result |
| in_a | input | 128 | First source operand |
| in_b | input | 128 | Second source operand |
| in_c | input | 128 | Addend operand for multiply-add |
| out_valid | output | 1 | Result present this cycle |
| out_tag | output | 7 | Destination tag of the result |
| out_data | output | 128 | Result word |

## Verification
The ports show a corrupted valid or tag pipeline three cycles after the faulty issue. The result then arrives at the wrong cycle, appears when nothing was issued, or carries another operation's tag. A wrong lane-size decode or a carry that leaks across a lane boundary corrupts only the lanes next to the boundary, so the stimulus includes all-ones plus one, zero minus one and sign-boundary compares, which push every lane to its limit. A fault in the multiply-add sign extension shows only when an operand is negative, and a fault in the addend wrap shows only when the sum overflows, so both cases are driven directly.

// File: rtl/simd_int_pkg.sv
// Shared definitions for the partitioned SIMD integer unit.
// Assumes: opcodes are 4 bits wide; codes not listed here are treated as no-ops.
package simd_int_pkg;

    typedef enum logic [3:0] {
        OP_AND   = 4'd0,
        OP_OR    = 4'd1,
        OP_XOR   = 4'd2,
        OP_NOR   = 4'd3,
        OP_ADD   = 4'd4,
        OP_SUB   = 4'd5,
        OP_CMPEQ = 4'd6,
        OP_CMPGT = 4'd7,
        OP_MADD  = 4'd8
    } simd_op_e;

    localparam int NUM_WIDTHS = 3;   // 8, 16 and 32-bit lane variants

endpackage

// File: rtl/simd_lane_alu.sv
// Lane-partitioned add/sub/compare array for one fixed lane width.
// Assumes: DW is a multiple of LW. Every lane is computed on its own, so no
// carry or borrow can cross a lane edge. Non-lane opcodes give zero.
module simd_lane_alu
    import simd_int_pkg::*;
#(
    parameter int DW = 128,
    parameter int LW = 8
) (
    input  logic [3:0]    op,
    input  logic [DW-1:0] a,
    input  logic [DW-1:0] b,
    output logic [DW-1:0] res
);
    localparam int NL = DW / LW;

    for (genvar i = 0; i < NL; i++) begin : g_lane
        logic [LW-1:0] la, lb, lr;
        assign la = a[i*LW +: LW];
        assign lb = b[i*LW +: LW];

        // Per-lane operation select.
        always_comb begin
            case (op)
                OP_ADD:   lr = la + lb;
                OP_SUB:   lr = la - lb;
                OP_CMPEQ: lr = (la == lb) ? '1 : '0;
                OP_CMPGT: lr = ($signed(la) > $signed(lb)) ? '1 : '0;
                default:  lr = '0;
            endcase
        end

        assign res[i*LW +: LW] = lr;
    end

endmodule

// File: rtl/simd_madd.sv
// Four-lane signed 16x16 multiply plus 32-bit addend, wrapped to 32 bits.
// Assumes: a_lo/b_lo hold only the low halves of each 32-bit lane, packed.
module simd_madd #(
    parameter int DW = 128
) (
    input  logic [DW/2-1:0] a_lo,
    input  logic [DW/2-1:0] b_lo,
    input  logic [DW-1:0]   c,
    output logic [DW-1:0]   res
);
    localparam int NL = DW / 32;

    for (genvar i = 0; i < NL; i++) begin : g_mac
        logic signed [31:0] prod;
        // Signed product sign-extended to 32 bits, then wrapped sum.
        assign prod = $signed(a_lo[i*16 +: 16]) * $signed(b_lo[i*16 +: 16]);
        assign res[i*32 +: 32] = prod + c[i*32 +: 32];
    end

endmodule

// File: rtl/simd_int_unit.sv
// Three-stage partitioned SIMD integer unit.
// Stage 1 captures the operation, stage 2 computes every variant and selects
// one, stage 3 retimes the result onto the ports. Latency is fixed at 3.
// Assumes: DW is a multiple of 32; the lane-size code 3 behaves like 2.
module simd_int_unit
    import simd_int_pkg::*;
#(
    parameter int DW    = 128,
    parameter int TAG_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             in_valid,
    input  logic [3:0]       in_op,
    input  logic [1:0]       in_lsz,
    input  logic [TAG_W-1:0] in_tag,
    input  logic [DW-1:0]    in_a,
    input  logic [DW-1:0]    in_b,
    input  logic [DW-1:0]    in_c,
    output logic             out_valid,
    output logic [TAG_W-1:0] out_tag,
    output logic [DW-1:0]    out_data
);
    localparam int N32 = DW / 32;

    logic             s1_v;
    logic [3:0]       s1_op;
    logic [1:0]       s1_lsz;
    logic [TAG_W-1:0] s1_tag;
    logic [DW-1:0]    s1_a, s1_b, s1_c;

    logic             s2_v;
    logic [TAG_W-1:0] s2_tag;
    logic [DW-1:0]    s2_data;

    logic [NUM_WIDTHS-1:0][DW-1:0] lane_res;
    logic [DW/2-1:0]               a_lo, b_lo;
    logic [DW-1:0]                 madd_res;
    logic [DW-1:0]                 sel_res;
    logic [1:0]                    wsel;

    // Stage 1: capture the issued operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_v   <= 1'b0;
            s1_op  <= '0;
            s1_lsz <= '0;
            s1_tag <= '0;
            s1_a   <= '0;
            s1_b   <= '0;
            s1_c   <= '0;
        end else begin
            s1_v   <= in_valid;
            s1_op  <= in_op;
            s1_lsz <= in_lsz;
            s1_tag <= in_tag;
            s1_a   <= in_a;
            s1_b   <= in_b;
            s1_c   <= in_c;
        end
    end

    // One lane array per supported lane width.
    for (genvar k = 0; k < NUM_WIDTHS; k++) begin : g_width
        simd_lane_alu #(.DW(DW), .LW(8 << k)) u_alu (
            .op  (s1_op),
            .a   (s1_a),
            .b   (s1_b),
            .res (lane_res[k])
        );
    end

    // Gather the low halves of each 32-bit lane for the multiplier.
    for (genvar j = 0; j < N32; j++) begin : g_lo
        assign a_lo[j*16 +: 16] = s1_a[j*32 +: 16];
        assign b_lo[j*16 +: 16] = s1_b[j*32 +: 16];
    end

    simd_madd #(.DW(DW)) u_madd (
        .a_lo (a_lo),
        .b_lo (b_lo),
        .c    (s1_c),
        .res  (madd_res)
    );

    // Decode the lane-size code into a width index.
    always_comb begin
        case (s1_lsz)
            2'd0:    wsel = 2'd0;
            2'd1:    wsel = 2'd1;
            default: wsel = 2'd2;
        endcase
    end

    // Pick the result for the opcode held in stage 1.
    always_comb begin
        case (s1_op)
            OP_AND:   sel_res = s1_a & s1_b;
            OP_OR:    sel_res = s1_a | s1_b;
            OP_XOR:   sel_res = s1_a ^ s1_b;
            OP_NOR:   sel_res = ~(s1_a | s1_b);
            OP_ADD, OP_SUB, OP_CMPEQ, OP_CMPGT:
                      sel_res = lane_res[wsel];
            OP_MADD:  sel_res = madd_res;
            default:  sel_res = '0;
        endcase
    end

    // Stage 2: register the selected result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s2_v    <= 1'b0;
            s2_tag  <= '0;
            s2_data <= '0;
        end else begin
            s2_v    <= s1_v;
            s2_tag  <= s1_tag;
            s2_data <= sel_res;
        end
    end

    // Stage 3: drive the result ports from a clean register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_tag   <= '0;
            out_data  <= '0;
        end else begin
            out_valid <= s2_v;
            out_tag   <= s2_tag;
            out_data  <= s2_data;
        end
    end

endmodule

// File: rtl/simd_int_unit_chk.sv
// Property checker for simd_int_unit. It keeps its own three-deep record of
// what was issued and compares the ports against it.
// Assumes: bound to every instance of simd_int_unit.
module simd_int_unit_chk
    import simd_int_pkg::*;
#(
    parameter int DW    = 128,
    parameter int TAG_W = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic [3:0]       in_op,
    input logic [1:0]       in_lsz,
    input logic [TAG_W-1:0] in_tag,
    input logic [DW-1:0]    in_a,
    input logic [DW-1:0]    in_b,
    input logic [DW-1:0]    in_c,
    input logic             out_valid,
    input logic [TAG_W-1:0] out_tag,
    input logic [DW-1:0]    out_data
);
    logic [2:0]       hv;
    logic [TAG_W-1:0] htag [3];
    logic [3:0]       hop  [3];
    logic [1:0]       hlsz [3];
    logic [DW-1:0]    ha [3], hb [3], hc [3];
    logic             bytes_ok;
    logic [31:0]      mac0_exp;
    logic             is_cmp;

    // Record the last three issued operations.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hv <= '0;
        end else begin
            hv <= {hv[1:0], in_valid};
        end
        htag[0] <= in_tag; hop[0] <= in_op; hlsz[0] <= in_lsz;
        ha[0] <= in_a; hb[0] <= in_b; hc[0] <= in_c;
        for (int i = 1; i < 3; i++) begin
            htag[i] <= htag[i-1]; hop[i] <= hop[i-1]; hlsz[i] <= hlsz[i-1];
            ha[i] <= ha[i-1]; hb[i] <= hb[i-1]; hc[i] <= hc[i-1];
        end
    end

    // Every output byte is either all zeros or all ones.
    always_comb begin
        bytes_ok = 1'b1;
        for (int i = 0; i < DW/8; i++) begin
            if (out_data[i*8 +: 8] != 8'h00 && out_data[i*8 +: 8] != 8'hFF)
                bytes_ok = 1'b0;
        end
    end

    assign is_cmp   = (hop[2] == OP_CMPEQ) || (hop[2] == OP_CMPGT);
    assign mac0_exp = 32'($signed(ha[2][15:0]) * $signed(hb[2][15:0])) + hc[2][31:0];

    // R2
    valid_latency_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid == hv[2]);

    // R2
    tag_carry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> out_tag == htag[2]);

    // R3
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> !out_valid);

    // R4
    and_full_word_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hop[2] == OP_AND) |-> out_data == (ha[2] & hb[2]));

    // R7
    cmp_byte_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && is_cmp && hlsz[2] == 2'd0) |-> bytes_ok);

    // R9
    madd_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hop[2] == OP_MADD) |-> out_data[31:0] == mac0_exp);

    // R10
    undef_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && hop[2] > 4'd8) |-> out_data == '0);

endmodule

bind simd_int_unit simd_int_unit_chk #(.DW(DW), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_op     (in_op),
    .in_lsz    (in_lsz),
    .in_tag    (in_tag),
    .in_a      (in_a),
    .in_b      (in_b),
    .in_c      (in_c),
    .out_valid (out_valid),
    .out_tag   (out_tag),
    .out_data  (out_data)
);

// File: tb/test_simd_int_unit.sv
`timescale 1ns/1ps
// Scoreboard bench for simd_int_unit: the driver pushes expected results,
// and the monitor pops them and compares when results come out.
module test_simd_int_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [3:0]   in_op = '0;
    logic [1:0]   in_lsz = '0;
    logic [6:0]   in_tag = '0;
    logic [127:0] in_a = '0, in_b = '0, in_c = '0;
    logic         out_valid;
    logic [6:0]   out_tag;
    logic [127:0] out_data;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;
    logic [6:0] tag_ctr = 7'd1;

    logic [127:0] q_data [$];
    logic [6:0]   q_tag  [$];
    int           q_cyc  [$];
    string        q_req  [$];

    simd_int_unit i_simd_int_unit (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_op(in_op),
        .in_lsz(in_lsz), .in_tag(in_tag), .in_a(in_a), .in_b(in_b),
        .in_c(in_c), .out_valid(out_valid), .out_tag(out_tag),
        .out_data(out_data)
    );

    always #2 clk = ~clk;   // 250 MHz

    always @(posedge clk) cyc <= cyc + 1;

    // Expected result computed from the requirement text.
    function automatic logic [127:0] model(logic [3:0] op, logic [1:0] lsz,
                                           logic [127:0] a, logic [127:0] b,
                                           logic [127:0] c);
        logic [127:0] r;
        int w;
        logic [63:0] m, msb, la, lb, lr;
        logic signed [63:0] pa, pb, acc;
        r = '0;
        case (op)
            4'd0: r = a & b;
            4'd1: r = a | b;
            4'd2: r = a ^ b;
            4'd3: r = ~(a | b);
            4'd4, 4'd5, 4'd6, 4'd7: begin
                w   = (lsz == 2'd0) ? 8 : (lsz == 2'd1) ? 16 : 32;
                m   = (64'd1 << w) - 64'd1;
                msb = 64'd1 << (w - 1);
                for (int i = 0; i < 128 / w; i++) begin
                    la = 64'(a >> (i * w)) & m;
                    lb = 64'(b >> (i * w)) & m;
                    case (op)
                        4'd4:    lr = (la + lb) & m;
                        4'd5:    lr = (la - lb) & m;
                        4'd6:    lr = (la == lb) ? m : 64'd0;
                        default: lr = ((la ^ msb) > (lb ^ msb)) ? m : 64'd0;
                    endcase
                    r = r | (128'(lr) << (i * w));
                end
            end
            4'd8: begin
                for (int i = 0; i < 4; i++) begin
                    pa  = 64'($signed(a[32*i +: 16]));
                    pb  = 64'($signed(b[32*i +: 16]));
                    acc = pa * pb + $signed({32'd0, c[32*i +: 32]});
                    r[32*i +: 32] = acc[31:0];
                end
            end
            default: r = '0;
        endcase
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [127:0] act, input logic [127:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    // Driver: present one operation and push its expected result.
    task automatic issue(input logic [3:0] op, input logic [1:0] lsz,
                         input logic [127:0] a, input logic [127:0] b,
                         input logic [127:0] c, input string req);
        @(negedge clk);
        in_valid = 1'b1; in_op = op; in_lsz = lsz;
        in_a = a; in_b = b; in_c = c; in_tag = tag_ctr;
        q_data.push_back(model(op, lsz, a, b, c));
        q_tag.push_back(tag_ctr);
        q_cyc.push_back(cyc);
        q_req.push_back(req);
        tag_ctr = tag_ctr + 7'd1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    // Monitor: compare each result with the head of the queue.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q_data.size() == 0) begin
                check(1'b0, "R2", "result with nothing issued", 128'(out_tag), '0);
            end else begin
                logic [127:0] ed; logic [6:0] et; int ec; string er;
                ed = q_data.pop_front(); et = q_tag.pop_front();
                ec = q_cyc.pop_front();  er = q_req.pop_front();
                check(out_data == ed, er, "data", out_data, ed);
                check(out_tag == et, "R2", "tag", 128'(out_tag), 128'(et));
                check(cyc - ec == 3, "R2", "latency", 128'(cyc - ec), 128'(3));
            end
        end
    end

    initial begin
        #(200000 * 4);
        tests++; fails++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R3: reset state of the result ports.
        check(out_valid == 1'b0, "R3", "valid in reset", 128'(out_valid), '0);
        check(out_data == '0, "R3", "data in reset", out_data, '0);
        check(out_tag == '0, "R3", "tag in reset", 128'(out_tag), '0);
        @(negedge clk); rst_n = 1'b1;
        idle(2);

        // R4: full-word logic, lane size irrelevant.
        issue(4'd0, 2'd0, {4{32'hF0F0_1234}}, {4{32'h0FF0_FFFF}}, '0, "R4");
        issue(4'd1, 2'd1, {4{32'hA5A5_0000}}, {4{32'h0000_5A5A}}, '0, "R4");
        issue(4'd2, 2'd2, {8{16'hFFFF}}, {8{16'h1234}}, '0, "R4");
        issue(4'd3, 2'd3, {4{32'h8000_0001}}, {4{32'h0000_0100}}, '0, "R4");
        // R5: carries stay inside lanes for each size.
        issue(4'd4, 2'd0, {16{8'hFF}}, {16{8'h01}}, '0, "R5");
        issue(4'd4, 2'd1, {8{16'hFFFF}}, {8{16'h0001}}, '0, "R5");
        issue(4'd4, 2'd2, {4{32'hFFFF_FFFF}}, {4{32'h0000_0001}}, '0, "R5");
        issue(4'd4, 2'd3, {4{32'h7FFF_FFFF}}, {4{32'h0000_0001}}, '0, "R5");
        // R6: borrows stay inside lanes.
        issue(4'd5, 2'd0, '0, {16{8'h01}}, '0, "R6");
        issue(4'd5, 2'd1, {8{16'h0100}}, {8{16'h0001}}, '0, "R6");
        issue(4'd5, 2'd2, '0, {4{32'h0000_0001}}, '0, "R6");
        // R7: equality masks.
        issue(4'd6, 2'd0, 128'h00112233_44556677_8899AABB_CCDDEEFF,
                          128'h00112200_44556677_0099AABB_CCDDEE00, '0, "R7");
        issue(4'd6, 2'd2, {32'h1, 32'h2, 32'h3, 32'h4}, {32'h1, 32'h0, 32'h3, 32'h0}, '0, "R7");
        // R8: signed greater-than across sign boundaries.
        issue(4'd7, 2'd0, {8{8'h7F, 8'h80}}, {8{8'h80, 8'h7F}}, '0, "R8");
        issue(4'd7, 2'd1, {4{16'hFFFF, 16'h0005}}, {4{16'hFFFE, 16'h0005}}, '0, "R8");
        issue(4'd7, 2'd2, {32'h8000_0000, 32'h1, 32'hFFFF_FFFF, 32'h0},
                          {32'h7FFF_FFFF, 32'h0, 32'h0, 32'hFFFF_FFFF}, '0, "R8");
        // R9: signed multiply-add, negatives and wrap; lane size ignored.
        issue(4'd8, 2'd0, {32'hDEAD_8000, 32'h1234_7FFF, 32'h0000_FFFF, 32'h5555_0003},
                          {32'hBEEF_8000, 32'h0000_7FFF, 32'h0000_0002, 32'h9999_FFFB},
                          {32'hC000_0000, 32'h0000_0001, 32'h0000_0010, 32'hFFFF_FFFF}, "R9");
        issue(4'd8, 2'd3, {4{32'h0000_7FFF}}, {4{32'h0000_7FFF}}, {4{32'h8000_0000}}, "R9");
        // R10: undefined opcodes give zero but still carry tag and valid.
        issue(4'd9, 2'd0, '1, '1, '1, "R10");
        issue(4'd15, 2'd2, '1, 128'h1, '1, "R10");
        idle(5);

        // R1: back-to-back burst of mixed operations.
        for (int i = 0; i < 40; i++) begin
            issue(4'($urandom_range(0, 10)), 2'($urandom_range(0, 3)),
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom},
                  {$urandom, $urandom, $urandom, $urandom}, "R1");
        end
        idle(6);
        check(q_data.size() == 0, "R1", "all results returned",
              128'(q_data.size()), '0);

        // R3: reset with operations in flight; none may come out.
        issue(4'd4, 2'd0, '1, '1, '0, "R3");
        issue(4'd1, 2'd0, '1, '1, '0, "R3");
        @(negedge clk);
        in_valid = 1'b0; rst_n = 1'b0;
        q_data.delete(); q_tag.delete(); q_cyc.delete(); q_req.delete();
        @(negedge clk);
        check(out_valid == 1'b0 && out_data == '0, "R3", "flush on reset",
              out_data, '0);
        rst_n = 1'b1;
        begin
            int seen;
            seen = 0;
            for (int i = 0; i < 5; i++) begin
                @(negedge clk);
                if (out_valid) seen++;
            end
            check(seen == 0, "R3", "no stale result", 128'(seen), '0);
        end

        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule